// File: doc/BRIEF.md
# Multi-Channel TDD Frame Timing Generator

This block drives a set of timing lines that gate the transmit and receive paths of a time-division duplex system. A start trigger, accepted only while the block is idle and globally enabled, opens an optional startup delay measured in clock cycles. A train of equal-length frames follows. A frame position counter runs from zero to the frame length minus one inside each frame and then wraps.

Each output channel has its own window inside the frame, given by a rising count and a falling count, plus its own polarity and enable bits. All channels share the frame position, so their edges stay aligned to one another in every frame. A burst count fixes how many frames run. A burst count of zero makes the train run until the global enable is removed. A busy flag shows when frames are running. A one-cycle completion strobe marks the end of a finite burst.

All configuration inputs are flat, static ports. They are meant to be held stable while a burst runs.

Top module: `tdd_frame_gen`

## Requirements
- R1: While reset is asserted, and after it is released, each `ch_out` bit equals its `ch_pol` bit, and `running` and `done` are 0.
- R2: A `trig` that is sampled high at a rising edge, while `glob_en` is 1 and the block is idle, starts a sequence. Frame position 0 is present `start_dly` cycles after that edge: in the cycle that follows the edge when `start_dly` is 0, and that many cycles later otherwise. `running` is 0 during the delay.
- R3: Within a run, the frame position counts 0, 1, … up to L−1 and then returns to 0. L is `frame_len`, except that a `frame_len` of 0 is taken as a frame of one cycle.
- R4: A channel is active in the cycles where the frame position p satisfies `on` ≤ p < `off`. The channel therefore never pulses when `off` ≤ `on` or when `on` ≥ L. An `off` beyond L keeps the channel active until the frame ends.
- R5: `ch_out[i]` equals `ch_pol[i]` XOR (channel i active). Polarity 0 gives an idle-low line that pulses high. Polarity 1 gives an idle-high line that pulses low.
- R6: A channel whose `ch_en` bit is 0 holds its idle level (`ch_pol`) at all times.
- R7: With a nonzero `burst_cnt` N, exactly N frames run. `done` is then 1 for one cycle, in the cycle right after the last frame position of the last frame. The block is idle again in the cycle after that.
- R8: With `burst_cnt` 0, frames repeat with no limit for as long as `glob_en` stays 1.
- R9: `trig` has no effect while a sequence is in its delay, its frames or its completion cycle, and it has no effect while `glob_en` is 0.
- R10: While `glob_en` is 0, in the same cycle, every `ch_out` bit equals its polarity and `running` and `done` are 0. The sequence is abandoned, so a new `trig` is needed to start again.
- R11: `running` is 1 exactly in the cycles that carry a frame position. `done` is never 1 in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glob_en | input | 1 | Global enable; 0 forces idle |
| trig | input | 1 | Start request, sampled at the rising edge |
| frame_len | input | CW | Frame length in cycles (0 taken as 1) |
| start_dly | input | CW | Cycles between the trigger edge and the first frame |
| burst_cnt | input | BW | Number of frames; 0 means unlimited |
| ch_on | input | NCH*CW | Per-channel rising count, channel i in bits [i*CW +: CW] |
| ch_off | input | NCH*CW | Per-channel falling count, channel i in bits [i*CW +: CW] |
| ch_pol | input | NCH | Per-channel idle level |
| ch_en | input | NCH | Per-channel enable |
| ch_out | output | NCH | Channel timing lines |
| running | output | 1 | Frames in progress |
| done | output | 1 | One-cycle strobe after the final frame of a burst |

## Verification
A frame position that is off by one appears at once as shifted channel edges. The test reads every channel on every cycle, so such a slip is caught in the first frame it affects. A wrong burst or delay count shows up as `running` falling, or `done` firing, at the wrong cycle. A missed return to idle shows up as a later trigger that produces no frames. A sequencer that wrongly restarts on a trigger mid-run would reset the frame position. Every channel edge after that would move, so the error is visible within one frame.

// File: rtl/tdd_pkg.sv
package tdd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } tdd_state_e;

  typedef logic [31:0] wide_t;

  // frame length with the zero case folded onto one cycle
  function automatic wide_t eff_len(input wide_t len);
    return (len == '0) ? wide_t'(1) : len;
  endfunction

  // half-open window test on the frame position
  function automatic logic in_window(input wide_t pos, input wide_t lo, input wide_t hi);
    return (pos >= lo) && (pos < hi);
  endfunction

  // true when the frame now ending completes a finite burst
  function automatic logic is_last(input wide_t frames_done, input wide_t burst);
    return (burst != '0) && ((frames_done + 1) == burst);
  endfunction

  // true in the final cycle of the startup delay
  function automatic logic delay_over(input wide_t cnt, input wide_t dly);
    return (cnt + 1) >= dly;
  endfunction

endpackage

// File: rtl/tdd_seq.sv
module tdd_seq
  import tdd_pkg::*;
#(
  parameter int CW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          glob_en,
  input  logic          trig,
  input  logic [CW-1:0] frame_len,
  input  logic [CW-1:0] start_dly,
  input  logic [BW-1:0] burst_cnt,
  output tdd_state_e    state,
  output logic [CW-1:0] frame_pos,
  output logic          frame_end,
  output logic          last_frame,
  output logic          start_ok
);

  logic [CW-1:0] dly_cnt;
  logic [BW-1:0] frm_cnt;
  logic          dly_end;
  tdd_state_e    nxt;

  assign start_ok   = (state == ST_IDLE) && glob_en && trig;
  assign dly_end    = (state == ST_DELAY) && delay_over(wide_t'(dly_cnt), wide_t'(start_dly));
  assign frame_end  = (state == ST_RUN) &&
                      (wide_t'(frame_pos) == eff_len(wide_t'(frame_len)) - 1);
  assign last_frame = is_last(wide_t'(frm_cnt), wide_t'(burst_cnt));

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (start_ok) nxt = (start_dly == '0) ? ST_RUN : ST_DELAY;
      ST_DELAY: if (dly_end) nxt = ST_RUN;
      ST_RUN:   if (frame_end && last_frame) nxt = ST_DONE;
      ST_DONE:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
    if (!glob_en) nxt = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      dly_cnt   <= '0;
      frame_pos <= '0;
      frm_cnt   <= '0;
    end else begin
      state <= nxt;

      if (glob_en && (state == ST_DELAY) && !dly_end) dly_cnt <= dly_cnt + 1'b1;
      else                                            dly_cnt <= '0;

      if (glob_en && (state == ST_RUN) && !frame_end) frame_pos <= frame_pos + 1'b1;
      else                                            frame_pos <= '0;

      if (!glob_en || (state != ST_RUN)) frm_cnt <= '0;
      else if (frame_end)                frm_cnt <= frm_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/tdd_chan.sv
module tdd_chan
  import tdd_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic [CW-1:0] frame_pos,
  input  logic          run_act,
  input  logic [CW-1:0] on_cnt,
  input  logic [CW-1:0] off_cnt,
  input  logic          pol,
  input  logic          en,
  output logic          sig
);

  logic active;

  assign active = run_act && en &&
                  in_window(wide_t'(frame_pos), wide_t'(on_cnt), wide_t'(off_cnt));
  assign sig    = pol ^ active;

endmodule

// File: rtl/tdd_frame_gen.sv
module tdd_frame_gen
  import tdd_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int BW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              glob_en,
  input  logic              trig,
  input  logic [CW-1:0]     frame_len,
  input  logic [CW-1:0]     start_dly,
  input  logic [BW-1:0]     burst_cnt,
  input  logic [NCH*CW-1:0] ch_on,
  input  logic [NCH*CW-1:0] ch_off,
  input  logic [NCH-1:0]    ch_pol,
  input  logic [NCH-1:0]    ch_en,
  output logic [NCH-1:0]    ch_out,
  output logic              running,
  output logic              done
);

  tdd_state_e    seq_state;
  logic [CW-1:0] frame_pos;
  logic          frame_end;
  logic          last_frame;
  logic          start_ok;
  logic          run_act;

  tdd_seq #(.CW(CW), .BW(BW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .glob_en    (glob_en),
    .trig       (trig),
    .frame_len  (frame_len),
    .start_dly  (start_dly),
    .burst_cnt  (burst_cnt),
    .state      (seq_state),
    .frame_pos  (frame_pos),
    .frame_end  (frame_end),
    .last_frame (last_frame),
    .start_ok   (start_ok)
  );

  assign run_act = (seq_state == ST_RUN) && glob_en;
  assign running = run_act;
  assign done    = (seq_state == ST_DONE) && glob_en;

  for (genvar gi = 0; gi < NCH; gi++) begin : g_chan
    tdd_chan #(.CW(CW)) u_chan (
      .frame_pos (frame_pos),
      .run_act   (run_act),
      .on_cnt    (ch_on[gi*CW +: CW]),
      .off_cnt   (ch_off[gi*CW +: CW]),
      .pol       (ch_pol[gi]),
      .en        (ch_en[gi]),
      .sig       (ch_out[gi])
    );
  end

endmodule

// File: rtl/tdd_frame_gen_chk.sv
module tdd_frame_gen_chk
  import tdd_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           glob_en,
  input logic [NCH-1:0] ch_pol,
  input logic [NCH-1:0] ch_en,
  input logic [NCH-1:0] ch_out,
  input logic           running,
  input logic           done,
  input tdd_state_e     state,
  input logic [CW-1:0]  frame_pos,
  input logic [CW-1:0]  frame_len,
  input logic           frame_end,
  input logic           last_frame
);

  p_idle_levels_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |-> ((ch_out == ch_pol) && !running && !done));

  p_disabled_chan_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (((ch_out ^ ch_pol) & ~ch_en) == '0));

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(running));

  p_pos_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (wide_t'(frame_pos) < eff_len(wide_t'(frame_len))));

  p_frame_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !last_frame && glob_en) |=> (frame_pos == '0));

  p_done_to_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE) |=> (state == ST_IDLE));

  p_run_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |=> (state != ST_DELAY));

endmodule

bind tdd_frame_gen tdd_frame_gen_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .glob_en    (glob_en),
  .ch_pol     (ch_pol),
  .ch_en      (ch_en),
  .ch_out     (ch_out),
  .running    (running),
  .done       (done),
  .state      (seq_state),
  .frame_pos  (frame_pos),
  .frame_len  (frame_len),
  .frame_end  (frame_end),
  .last_frame (last_frame)
);

// File: tb/tdd_frame_gen_bench.sv
module tdd_frame_gen_bench;

  localparam int NCH = 4;
  localparam int CW  = 16;
  localparam int BW  = 8;

  typedef struct packed {
    logic [15:0] len;
    logic [15:0] dly;
    logic [7:0]  burst;
    logic [15:0] on;
    logic [15:0] off;
    logic        pol;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{16'd8,  16'd0, 8'd2, 16'd0, 16'd3,  1'b0},
    '{16'd5,  16'd3, 8'd1, 16'd2, 16'd9,  1'b1},
    '{16'd6,  16'd1, 8'd0, 16'd1, 16'd4,  1'b0},
    '{16'd0,  16'd2, 8'd3, 16'd0, 16'd1,  1'b0},
    '{16'd4,  16'd0, 8'd1, 16'd4, 16'd6,  1'b1},
    '{16'd7,  16'd5, 8'd2, 16'd5, 16'd2,  1'b0},
    '{16'd12, 16'd2, 8'd2, 16'd0, 16'd10, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              glob_en;
  logic              trig;
  logic [CW-1:0]     frame_len;
  logic [CW-1:0]     start_dly;
  logic [BW-1:0]     burst_cnt;
  logic [NCH*CW-1:0] ch_on;
  logic [NCH*CW-1:0] ch_off;
  logic [NCH-1:0]    ch_pol;
  logic [NCH-1:0]    ch_en;
  logic [NCH-1:0]    ch_out;
  logic              running;
  logic              done;

  int n_chk  = 0;
  int n_fail = 0;

  int c_on  [NCH];
  int c_off [NCH];
  int c_pol [NCH];
  int c_en  [NCH];

  always #5 clk = ~clk;

  tdd_frame_gen #(.NCH(NCH), .CW(CW), .BW(BW)) u_tdd_frame_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .glob_en   (glob_en),
    .trig      (trig),
    .frame_len (frame_len),
    .start_dly (start_dly),
    .burst_cnt (burst_cnt),
    .ch_on     (ch_on),
    .ch_off    (ch_off),
    .ch_pol    (ch_pol),
    .ch_en     (ch_en),
    .ch_out    (ch_out),
    .running   (running),
    .done      (done)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic int efl(input int l);
    return (l == 0) ? 1 : l;
  endfunction

  function automatic bit exp_run(input int t, input int d, input int l, input int b);
    if (t < d) return 1'b0;
    if ((b != 0) && ((t - d) >= b * efl(l))) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit exp_act(input int t, input int d, input int l, input int b,
                                 input int lo, input int hi);
    int p;
    if (!exp_run(t, d, l, b)) return 1'b0;
    p = (t - d) % efl(l);
    return (p >= lo) && (p < hi);
  endfunction

  task automatic drive_cfg();
    for (int i = 0; i < NCH; i++) begin
      ch_on[i*CW +: CW]  = CW'(c_on[i]);
      ch_off[i*CW +: CW] = CW'(c_off[i]);
      ch_pol[i]          = c_pol[i][0];
      ch_en[i]           = c_en[i][0];
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired got=hung exp=finished");
    summary();
    $finish;
  end

  initial begin
    int d, l, b, lst;
    logic [NCH-1:0] exp_out;
    rst_n     = 1'b0;
    glob_en   = 1'b0;
    trig      = 1'b0;
    frame_len = 16'd8;
    start_dly = '0;
    burst_cnt = 8'd1;
    c_on  = '{0, 1, 0, 2};
    c_off = '{3, 3, 5, 2};
    c_pol = '{0, 1, 1, 0};
    c_en  = '{1, 1, 0, 1};
    drive_cfg();

    // R1: reset values
    repeat (3) @(negedge clk);
    check("R1 ch_out in reset", 32'(ch_out), 32'(ch_pol));
    check("R1 running in reset", 32'(running), 32'd0);
    rst_n = 1'b1;
    glob_en = 1'b1;
    @(negedge clk);
    check("R1 ch_out after reset", 32'(ch_out), 32'(ch_pol));
    check("R1 done after reset", 32'(done), 32'd0);

    // vector table: channel 0 follows the table, others fixed
    for (int v = 0; v < NV; v++) begin
      d = int'(VECS[v].dly);
      l = int'(VECS[v].len);
      b = int'(VECS[v].burst);
      frame_len = VECS[v].len;
      start_dly = VECS[v].dly;
      burst_cnt = VECS[v].burst;
      c_on[0]  = int'(VECS[v].on);
      c_off[0] = int'(VECS[v].off);
      c_pol[0] = int'(VECS[v].pol);
      drive_cfg();
      glob_en = 1'b1;
      @(negedge clk);
      check("R2 idle before trigger", 32'(running), 32'd0);
      trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
      lst = (b != 0) ? d + b * efl(l) + 2 : d + 3 * efl(l) + 2;
      for (int t = 0; t <= lst; t++) begin
        for (int i = 0; i < NCH; i++)
          exp_out[i] = c_pol[i][0] ^ (c_en[i][0] && exp_act(t, d, l, b, c_on[i], c_off[i]));
        check("R3 R4 R5 R6 ch_out", 32'(ch_out), 32'(exp_out));
        if (b == 0) check("R8 running", 32'(running), 32'(exp_run(t, d, l, b)));
        else        check("R2 R11 running", 32'(running), 32'(exp_run(t, d, l, b)));
        check("R7 done", 32'(done), 32'((b != 0) && (t == d + b * efl(l))));
        // R9: triggers mid-run and in the completion cycle must be ignored
        if ((t == d + 1) || ((b != 0) && (t == d + b * efl(l)))) trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
      end
      if (b == 0) begin
        // R10: dropping the global enable forces idle at once
        glob_en = 1'b0;
        #1;
        check("R10 ch_out idle", 32'(ch_out), 32'(ch_pol));
        check("R10 running low", 32'(running), 32'd0);
        @(negedge clk);
        glob_en = 1'b1;
        @(negedge clk);
        check("R10 stays idle without trigger", 32'(running), 32'd0);
      end
    end

    // R9: trigger with global enable low is ignored
    frame_len = 16'd4;
    start_dly = '0;
    burst_cnt = 8'd0;
    glob_en = 1'b0;
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    glob_en = 1'b1;
    for (int k = 0; k < 3; k++) begin
      check("R9 trigger while disabled", 32'(running), 32'd0);
      check("R9 outputs idle", 32'(ch_out), 32'(ch_pol));
      @(negedge clk);
    end

    summary();
    $finish;
  end

endmodule